// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synchronous static RAM of the kind placed beside a processor as cache memory. Its default depth is small to keep elaboration light. The full-size part is 32,768 words of 32 bits, which is `AW = 15`. On each rising clock edge the block captures the address, the control inputs and the write data in registers. Read data has no output register: it comes straight from the array during the cycle that follows the capturing edge.

An internal two-bit counter turns one start address into a burst of four words. The counter moves forward on each edge at which `step_n` is low. It walks the aligned group of four words in either linear order or interleaved order, and it never carries into the upper address bits.

A write is decided at the capturing edge and committed to the array at the next edge. Writes are controlled at three levels: whole word, byte-enable gate, and per-lane selects.

Selection needs all three select pins in their active states. Output enable gates the read data without waiting for a clock edge. A sleep input makes the block ignore accesses.

The data bus is split into `din`, `dout` and a drive-enable output `dout_oe`. This is a plain pin interface with no back-pressure: every clock cycle is one access slot, and neither side can stall the other.

Top module: `sbsram_flow`

## Requirements
- R1: After an edge that loads address A while the block is selected, no write is captured and `out_en_n` is low, `dout` equals word A and `dout_oe` is high in that same cycle.
- R2: With `order_lin` = 1 at the load edge, the low two address bits of the burst are s, s+1, s+2, s+3 modulo 4, where s is the start value.
- R3: With `order_lin` = 0 at the load edge, the low two address bits of the burst are s^0, s^1, s^2, s^3.
- R4: At an edge with no strobe and `step_n` high, the address is held and the same word is presented again.
- R5: The burst stays inside its aligned four-word group. Address bits 2 and above never change during a burst.
- R6: A load happens at an edge where either `cpu_strobe_n` or `ctl_strobe_n` is low.
- R7: The block is selected only when `ce_n` = 0, `cs_en` = 1 and `cs_n` = 0 at the load edge. A load without selection deselects the block: `dout_oe` goes low, and writes are ignored until the next selected load.
- R8: A low `wr_all_n` at an edge writes all four byte lanes of the current address.
- R9: When `wr_all_n` is high and `wr_bytes_n` is low, only the lanes i whose `lane_sel_n[i]` is low are written. Lane i is bits 8i+7 down to 8i. When both are high, the access is a read.
- R10: Write control and data are captured at one edge and written to the array at the next edge. In the cycle between those two edges, `dout_oe` is low and `dout` is zero.
- R11: `out_en_n` acts without a clock. When it is high, `dout_oe` is low and `dout` is zero.
- R12: While `sleep` is high, `dout_oe` is low. An edge taken during sleep performs no write and leaves the block deselected.
- R13: The asynchronous reset `rst_n` low deselects the block, so `dout_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; inputs are captured on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control registers |
| sleep | input | 1 | Power-down; the block ignores accesses while it is high |
| ce_n | input | 1 | Active-low enable |
| cs_en | input | 1 | Active-high select |
| cs_n | input | 1 | Active-low select |
| cpu_strobe_n | input | 1 | Address load strobe driven by the processor |
| ctl_strobe_n | input | 1 | Address load strobe driven by the cache controller |
| step_n | input | 1 | Active-low burst advance |
| order_lin | input | 1 | 1 = linear burst order, 0 = interleaved |
| addr | input | AW | Word address |
| wr_all_n | input | 1 | Active-low whole-word write |
| wr_bytes_n | input | 1 | Active-low gate for the lane selects |
| lane_sel_n | input | DW/8 | Active-low per-lane write selects |
| din | input | DW | Write data |
| out_en_n | input | 1 | Active-low output enable, acts without a clock |
| dout | output | DW | Read data, zero when not driven |
| dout_oe | output | 1 | High when the block drives read data |

## Verification
The bench runs all four start offsets in both burst orders. A counter that carried into bit 2, or that swapped the two orders, would return a word from the wrong group or in the wrong sequence. A partial-lane write is checked against a word written earlier, which catches a lane mask that is reversed or ignores the gate. Writes attempted while deselected and while asleep are followed by read-back of the same address, which exposes a design that lets them reach the array. Output enable and reset are toggled between clock edges to show that a design which registered them would leave the bus driven.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  // low two address bits for beat `step` of a burst that starts at `start`
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] step,
                                           input logic       linear);
    return linear ? (start + step) : (start ^ step);
  endfunction
endpackage

// File: rtl/sbsram_burst_seq.sv
module sbsram_burst_seq
  import sbsram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep,
  input  logic          sel,
  input  logic          load,
  input  logic          step_n,
  input  logic          order_lin,
  input  logic [AW-1:0] addr,
  output logic          active,
  output logic          go,
  output logic [AW-1:0] cur_addr
);
  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  logic          order_q;

  // the block is active after this edge
  assign go = !sleep && (load ? sel : active);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      base_q  <= '0;
      cnt_q   <= '0;
      order_q <= 1'b1;
    end else if (sleep) begin
      active <= 1'b0;
    end else if (load) begin
      active  <= sel;
      base_q  <= addr;
      cnt_q   <= '0;
      order_q <= order_lin;
    end else if (active && !step_n) begin
      cnt_q <= cnt_q + 2'd1;
    end
  end

  assign cur_addr = {base_q[AW-1:2], burst_low(base_q[1:0], cnt_q, order_q)};

  // R4
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !load && step_n) |=> $stable(cur_addr));
  // R5
  group_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load) |=> (cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])));
  // R12
  sleep_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !active);
endmodule

// File: rtl/sbsram_wr_ctrl.sv
module sbsram_wr_ctrl #(
  parameter int DW = 32,
  localparam int LANES = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             wr_all_n,
  input  logic             wr_bytes_n,
  input  logic [LANES-1:0] lane_sel_n,
  input  logic [DW-1:0]    din,
  output logic [LANES-1:0] mask_q,
  output logic [DW-1:0]    wdata_q
);
  logic [LANES-1:0] mask_d;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mask_d[i] = !wr_all_n || (!wr_bytes_n && !lane_sel_n[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      wdata_q <= '0;
    end else begin
      mask_q  <= go ? mask_d : '0;
      wdata_q <= din;
    end
  end

  // R8
  full_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !wr_all_n) |=> (mask_q == {LANES{1'b1}}));
  // R9
  read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_all_n && wr_bytes_n) |=> (mask_q == '0));
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int AW = 8,
  parameter int DW = 32,
  localparam int LANES = DW / 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic             clk,
  input  logic [AW-1:0]    a,
  input  logic [LANES-1:0] we,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [7:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we[i]) mem[a] <= wdata[8*i +: 8];
    end
    assign rdata[8*i +: 8] = mem[a];
  end
endmodule

// File: rtl/sbsram_flow.sv
module sbsram_flow #(
  parameter int AW = 8,
  parameter int DW = 32,
  localparam int LANES = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep,
  input  logic             ce_n,
  input  logic             cs_en,
  input  logic             cs_n,
  input  logic             cpu_strobe_n,
  input  logic             ctl_strobe_n,
  input  logic             step_n,
  input  logic             order_lin,
  input  logic [AW-1:0]    addr,
  input  logic             wr_all_n,
  input  logic             wr_bytes_n,
  input  logic [LANES-1:0] lane_sel_n,
  input  logic [DW-1:0]    din,
  input  logic             out_en_n,
  output logic [DW-1:0]    dout,
  output logic             dout_oe
);
  logic             sel, load, active, go;
  logic [AW-1:0]    cur_addr;
  logic [LANES-1:0] mask_q;
  logic [DW-1:0]    wdata_q, rdata;

  assign sel  = !ce_n && cs_en && !cs_n;
  assign load = !cpu_strobe_n || !ctl_strobe_n;

  sbsram_burst_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .sel(sel), .load(load),
    .step_n(step_n), .order_lin(order_lin), .addr(addr),
    .active(active), .go(go), .cur_addr(cur_addr)
  );

  sbsram_wr_ctrl #(.DW(DW)) u_wr (
    .clk(clk), .rst_n(rst_n), .go(go), .wr_all_n(wr_all_n),
    .wr_bytes_n(wr_bytes_n), .lane_sel_n(lane_sel_n), .din(din),
    .mask_q(mask_q), .wdata_q(wdata_q)
  );

  sbsram_array #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .a(cur_addr), .we(mask_q), .wdata(wdata_q), .rdata(rdata)
  );

  assign dout_oe = active && (mask_q == '0) && !out_en_n && !sleep;
  assign dout    = dout_oe ? rdata : '0;

  // R10
  wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !wr_all_n) |=> !dout_oe);
endmodule

// File: tb/sbsram_flow_tb.sv
module sbsram_flow_tb;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0, rst_n = 1'b0, sleep, ce_n, cs_en, cs_n;
  logic cpu_strobe_n, ctl_strobe_n, step_n, order_lin, wr_all_n, wr_bytes_n, out_en_n;
  logic [AW-1:0] addr;
  logic [3:0]    lane_sel_n;
  logic [DW-1:0] din, dout;
  logic          dout_oe;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  sbsram_flow #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .ce_n(ce_n), .cs_en(cs_en), .cs_n(cs_n),
    .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n), .step_n(step_n),
    .order_lin(order_lin), .addr(addr), .wr_all_n(wr_all_n), .wr_bytes_n(wr_bytes_n),
    .lane_sel_n(lane_sel_n), .din(din), .out_en_n(out_en_n), .dout(dout), .dout_oe(dout_oe)
  );

  // {linear, start, expected low bits of beats 0..3}
  localparam logic [10:0] VEC [8] = '{
    {1'b1, 2'd0, 8'h1B}, {1'b1, 2'd1, 8'h6C}, {1'b1, 2'd2, 8'hB1}, {1'b1, 2'd3, 8'hC6},
    {1'b0, 2'd0, 8'h1B}, {1'b0, 2'd1, 8'h4E}, {1'b0, 2'd2, 8'hB1}, {1'b0, 2'd3, 8'hE4}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    sleep = 0; ce_n = 0; cs_en = 1; cs_n = 0; cpu_strobe_n = 1; ctl_strobe_n = 1;
    step_n = 1; order_lin = 1; wr_all_n = 1; wr_bytes_n = 1; lane_sel_n = 4'hF;
    out_en_n = 0; din = '0;
  endtask

  task automatic tick();
    @(posedge clk); #5;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    idle(); addr = a; din = d; cpu_strobe_n = 0; wr_all_n = 0; tick();
    idle(); tick();
  endtask

  task automatic ld(input logic [AW-1:0] a, input logic lin);
    idle(); addr = a; order_lin = lin; cpu_strobe_n = 0; tick(); idle();
  endtask

  task automatic adv();
    idle(); step_n = 0; tick(); idle();
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(); addr = '0;
    tick(); tick();
    chk("R13 reset deselects", {31'd0, dout_oe}, 32'd0);
    rst_n = 1; tick();

    // R8: whole-word writes fill group 0x10..0x13
    for (int a = 16; a < 20; a++) wr(AW'(a), 32'hC0DE0000 | a);
    chk("R8 full write", dout, 32'hC0DE0013);

    // R1 R2 R3 R5: every start offset in both orders
    for (int i = 0; i < 8; i++) begin
      ld(AW'(8'h10 | VEC[i][9:8]), VEC[i][10]);
      for (int k = 0; k < 4; k++) begin
        if (k > 0) adv();
        chk(VEC[i][10] ? "R2 linear beat (R1 flow)" : "R3 interleaved beat (R1 flow)",
            dout, 32'hC0DE0010 | 32'(VEC[i][7-2*k -: 2]));
      end
    end

    // R5: wrap stays in group
    ld(8'h13, 1'b1); adv();
    chk("R5 wrap in group", dout, 32'hC0DE0010);

    // R6: controller strobe loads
    idle(); addr = 8'h11; ctl_strobe_n = 0; tick(); idle();
    chk("R6 ctl strobe load", dout, 32'hC0DE0011);
    // R4: hold with advance high
    tick();
    chk("R4 hold", dout, 32'hC0DE0011);

    // R11: output enable without a clock
    out_en_n = 1; #1;
    chk("R11 oe off", {31'd0, dout_oe}, 32'd0);
    chk("R11 data zero", dout, 32'd0);
    out_en_n = 0; #1;
    chk("R11 oe on", dout, 32'hC0DE0011);

    // R9 R10: partial lanes 0 and 2
    wr(8'h20, 32'h11223344);
    idle(); addr = 8'h20; cpu_strobe_n = 0; wr_bytes_n = 0; lane_sel_n = 4'b1010;
    din = 32'hFFFFFFFF; tick();
    chk("R10 no drive in write cycle", {31'd0, dout_oe}, 32'd0);
    idle(); tick();
    chk("R9 lane write", dout, 32'h11FF33FF);
    // R9: lane selects without the gate read
    idle(); addr = 8'h20; cpu_strobe_n = 0; lane_sel_n = 4'h0; tick();
    chk("R9 read drives", {31'd0, dout_oe}, 32'd1);
    idle(); tick();
    chk("R9 no write", dout, 32'h11FF33FF);

    // R7: deselected write ignored
    idle(); ce_n = 1; addr = 8'h20; cpu_strobe_n = 0; wr_all_n = 0; tick();
    chk("R7 deselected", {31'd0, dout_oe}, 32'd0);
    idle(); tick();
    ld(8'h20, 1'b1);
    chk("R7 write ignored", dout, 32'h11FF33FF);

    // R12: sleep
    idle(); sleep = 1; addr = 8'h20; cpu_strobe_n = 0; wr_all_n = 0; #1;
    chk("R12 sleep drive off", {31'd0, dout_oe}, 32'd0);
    tick();
    chk("R12 asleep", {31'd0, dout_oe}, 32'd0);
    idle(); tick();
    chk("R12 stays deselected", {31'd0, dout_oe}, 32'd0);
    ld(8'h20, 1'b1);
    chk("R12 write ignored", dout, 32'h11FF33FF);

    // R13: reset mid-run
    rst_n = 0; #1;
    chk("R13 async reset", {31'd0, dout_oe}, 32'd0);
    rst_n = 1; tick();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule